// File: doc/BRIEF.md
# Splittable Performance Counter Bank

This block is a bank of event counters for hardware performance monitoring. It holds four physical counters. Each one runs either as a single 32-bit counter or as two separate 16-bit counters, so the bank offers eight logical counters. Every logical counter has its own single-cycle event input. A counter is advanced only while the bank is globally enabled.

Software does not load a counter directly. A write to a counter goes into a per-counter holding register and marks that counter as pending. The live counter picks up the held value only when the control register is written with its enable bit set. This holds even when the written value matches the current one, so software can load several counters and start them together. A status register collects one wrap flag per logical counter. Reading the status register clears those flags. Its write side sets an interrupt enable mask, and the interrupt output is the OR of the flags that are enabled.

The register port is a plain single-cycle access port with no back-pressure. Every access is taken in the cycle it is presented, and read data appears one cycle later. The event inputs are plain level-sampled pulses with no handshake.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset every counter, holding register, pending mark, control bit, status flag and mask bit is zero, `irq_o` is 0 and `rd_data` is 0.
- R2: Register map: addresses 0–7 are the logical counters, 8 is control and 9 is status. Control bit 0 is the global enable, and control bit 1+p puts physical counter p in 16-bit mode. Read data for an access with `rd_en` high appears on `rd_data` after the next rising edge. Addresses 10–15 read as zero.
- R3: In 32-bit mode, logical counters p and p+4 both address the full physical counter p. It is advanced by `evt_i[p]`, and `evt_i[p+4]` has no effect.
- R4: In 16-bit mode, logical counter p is the upper half and p+4 the lower half of physical counter p, each read back zero-extended. `evt_i[p]` advances the upper half and `evt_i[p+4]` the lower half. Each half wraps on its own with no carry or borrow into the other.
- R5: Counters change on events only while control bit 0 is set.
- R6: A counter write only fills that counter's holding register and marks it pending. While it is pending, reads return the held value, and events do not change what is read.
- R7: A control write with bit 0 set loads every pending holding value into its live counter and clears all pending marks, even when the control value is unchanged. A control write with bit 0 clear loads nothing.
- R8: In 16-bit mode, a logical write replaces only its half. The other half of the held value is taken from the counter's current read value (held value if pending, else live).
- R9: A wrap from all-ones to zero sets a status flag. A 32-bit counter or upper half p sets flag p, and a lower half p sets flag p+4. A status read returns the flags in bits 7:0 and the mask in bits 15:8.
- R10: A status read clears the flags it returns. A wrap in the same cycle as the read stays set and is returned by the next read.
- R11: A status write loads the mask from `wr_data[7:0]` without touching the flags. `irq_o` is high exactly when some flag and its mask bit are both set, so writing zero drops `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | One event pulse per logical counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_o | output | 1 | Masked overflow interrupt |

## Verification
The two functions that can coincide are the clear-on-read of the status flags and a counter wrap that sets a flag. The bench loads a counter with all-ones and commits it. It then presents a status read and that counter's event pulse at the same falling edge, with another flag already set beforehand. The first read must return only the older flag, and the following read must return the flag raised in the collision cycle.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  typedef enum logic [1:0] {
    ACC_CTR  = 2'd0,
    ACC_CTRL = 2'd1,
    ACC_STAT = 2'd2,
    ACC_NONE = 2'd3
  } acc_kind_e;

  // Counters occupy [0, nlog); control and status follow directly.
  function automatic acc_kind_e classify(input int unsigned a, input int unsigned nlog);
    if (a < nlog)           return ACC_CTR;
    else if (a == nlog)     return ACC_CTRL;
    else if (a == nlog + 1) return ACC_STAT;
    else                    return ACC_NONE;
  endfunction

endpackage

// File: rtl/pcb_ctrl.sv
module pcb_ctrl #(
  parameter int NUM_PHYS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [NUM_PHYS:0]   wdata_i,
  output logic                enable_o,
  output logic [NUM_PHYS-1:0] split_o,
  output logic                commit_o,
  output logic [NUM_PHYS:0]   ctrl_o
);

  logic [NUM_PHYS:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    ctrl_q <= '0;
    else if (wr_i) ctrl_q <= wdata_i;
  end

  // Any control write that leaves the bank enabled publishes pending values.
  assign commit_o = wr_i && wdata_i[0];
  assign enable_o = ctrl_q[0];
  assign split_o  = ctrl_q[NUM_PHYS:1];
  assign ctrl_o   = ctrl_q;

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ctrl_q));

endmodule

// File: rtl/pcb_slice.sv
module pcb_slice #(
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             split_i,
  input  logic             evt_hi_i,
  input  logic             evt_lo_i,
  input  logic             wr_i,
  input  logic             wlow_i,
  input  logic [CTR_W-1:0] wdata_i,
  input  logic             commit_i,
  output logic [CTR_W-1:0] view_o,
  output logic             ovf_hi_o,
  output logic             ovf_lo_o
);

  localparam int HALF = CTR_W / 2;

  logic [CTR_W-1:0] live_q, latch_q, merged;
  logic             pend_q, load;
  logic [HALF-1:0]  hi_inc, lo_inc;

  assign view_o = pend_q ? latch_q : live_q;
  assign load   = commit_i && pend_q;

  // A half-width write keeps the other half of whatever is currently visible.
  always_comb begin
    merged = wdata_i;
    if (split_i) begin
      if (wlow_i) merged = {view_o[CTR_W-1:HALF], wdata_i[HALF-1:0]};
      else        merged = {wdata_i[HALF-1:0], view_o[HALF-1:0]};
    end
  end

  assign hi_inc = HALF'(evt_hi_i);
  assign lo_inc = HALF'(evt_lo_i);

  // A committing counter takes the held value; that cycle's event is dropped.
  always_comb begin
    ovf_hi_o = en_i && !load && evt_hi_i &&
               (split_i ? (&live_q[CTR_W-1:HALF]) : (&live_q));
    ovf_lo_o = en_i && !load && split_i && evt_lo_i && (&live_q[HALF-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q  <= '0;
      latch_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (wr_i) begin
        latch_q <= merged;
        pend_q  <= 1'b1;
      end else if (commit_i) begin
        pend_q  <= 1'b0;
      end
      if (load) begin
        live_q <= latch_q;
      end else if (en_i) begin
        if (split_i) begin
          live_q[CTR_W-1:HALF] <= live_q[CTR_W-1:HALF] + hi_inc;
          live_q[HALF-1:0]     <= live_q[HALF-1:0] + lo_inc;
        end else begin
          live_q <= live_q + CTR_W'(evt_hi_i);
        end
      end
    end
  end

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && pend_q && !wr_i) |=> !pend_q);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !commit_i) |=> $stable(live_q));

  // R4
  no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && split_i && !load && evt_lo_i && !evt_hi_i && (&live_q[HALF-1:0]))
      |=> (live_q[CTR_W-1:HALF] == $past(live_q[CTR_W-1:HALF])));

endmodule

// File: rtl/pcb_status.sv
module pcb_status #(
  parameter int NLOG = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLOG-1:0] ovf_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [NLOG-1:0] mask_i,
  output logic [NLOG-1:0] flags_o,
  output logic [NLOG-1:0] mask_o,
  output logic            irq_o
);

  logic [NLOG-1:0] flags_q, mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
    end else begin
      // New wraps are ORed in after the read-clear so none is lost.
      flags_q <= (rd_i ? '0 : flags_q) | ovf_i;
      if (wr_i) mask_q <= mask_i;
    end
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign irq_o   = |(flags_q & mask_q);

  // R10
  keep_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_i) |=> ((flags_q & $past(ovf_i)) == $past(ovf_i)));

  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !(|ovf_i)) |=> (flags_q == '0));

  // R11
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (mask_q == $past(mask_i)));

endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
  import pcb_pkg::*;
#(
  parameter  int NUM_PHYS = 4,
  parameter  int CTR_W    = 32,
  localparam int NLOG     = 2 * NUM_PHYS,
  localparam int AW       = $clog2(NLOG) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLOG-1:0]  evt_i,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CTR_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [CTR_W-1:0] rd_data,
  output logic             irq_o
);

  localparam int HALF = CTR_W / 2;
  localparam int PW   = $clog2(NUM_PHYS);

  acc_kind_e wr_kind, rd_kind;
  assign wr_kind = classify(32'(wr_addr), NLOG);
  assign rd_kind = classify(32'(rd_addr), NLOG);

  logic [PW-1:0] wr_phys, rd_phys;
  assign wr_phys = wr_addr[PW-1:0];
  assign rd_phys = rd_addr[PW-1:0];

  logic                enable_w, commit_w;
  logic [NUM_PHYS-1:0] split_w;
  logic [NUM_PHYS:0]   ctrl_w;

  pcb_ctrl #(.NUM_PHYS(NUM_PHYS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr_en && (wr_kind == ACC_CTRL)),
    .wdata_i  (wr_data[NUM_PHYS:0]),
    .enable_o (enable_w),
    .split_o  (split_w),
    .commit_o (commit_w),
    .ctrl_o   (ctrl_w)
  );

  logic [CTR_W-1:0]    view_w [NUM_PHYS];
  logic [NUM_PHYS-1:0] ovf_hi_w, ovf_lo_w;

  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_slice
    pcb_slice #(.CTR_W(CTR_W)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (enable_w),
      .split_i  (split_w[p]),
      .evt_hi_i (evt_i[p]),
      .evt_lo_i (evt_i[p+NUM_PHYS]),
      .wr_i     (wr_en && (wr_kind == ACC_CTR) && (wr_phys == PW'(p))),
      .wlow_i   (wr_addr[PW]),
      .wdata_i  (wr_data),
      .commit_i (commit_w),
      .view_o   (view_w[p]),
      .ovf_hi_o (ovf_hi_w[p]),
      .ovf_lo_o (ovf_lo_w[p])
    );
  end

  logic [NLOG-1:0] flags_w, mask_w;

  pcb_status #(.NLOG(NLOG)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .ovf_i   ({ovf_lo_w, ovf_hi_w}),
    .rd_i    (rd_en && (rd_kind == ACC_STAT)),
    .wr_i    (wr_en && (wr_kind == ACC_STAT)),
    .mask_i  (wr_data[NLOG-1:0]),
    .flags_o (flags_w),
    .mask_o  (mask_w),
    .irq_o   (irq_o)
  );

  logic [CTR_W-1:0] rd_view, rd_val, rd_q;
  logic             rd_split;
  assign rd_view  = view_w[rd_phys];
  assign rd_split = split_w[rd_phys];

  always_comb begin
    rd_val = '0;
    unique case (rd_kind)
      ACC_CTR: begin
        if (rd_split) rd_val = rd_addr[PW] ? CTR_W'(rd_view[HALF-1:0])
                                           : CTR_W'(rd_view[CTR_W-1:HALF]);
        else          rd_val = rd_view;
      end
      ACC_CTRL: rd_val = CTR_W'(ctrl_w);
      ACC_STAT: rd_val = CTR_W'({mask_w, flags_w});
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_val;
  end

  assign rd_data = rd_q;

endmodule

// File: tb/perf_ctr_bank_test.sv
module perf_ctr_bank_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt_i = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_o;

  int n_run = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  perf_ctr_bank uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic pulse(input logic [7:0] m, input int cyc);
    @(negedge clk); evt_i = m;
    repeat (cyc) @(negedge clk);
    evt_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, x;
    logic [31:0] a_val [4];
    logic [15:0] u_val [4];
    logic [15:0] l_val [4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 R2: reset state over every address
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      check($sformatf("R1 reset addr %0d", a), v, 32'h0);
    end
    check("R1 irq after reset", 32'(irq_o), 32'h0);

    // R3: 32-bit mode counting, upper-address event ignored
    wr(4'd8, 32'h1);
    rd(4'd8, v); check("R2 control readback", v, 32'h1);
    for (int p = 0; p < 4; p++) pulse(8'((1 << p) | (1 << (p + 4))), p + 2);
    for (int n = 0; n < 8; n++) begin
      rd(4'(n), v);
      check($sformatf("R3 logical %0d", n), v, 32'((n % 4) + 2));
    end

    // R5: disabled bank ignores events
    wr(4'd8, 32'h0);
    pulse(8'hFF, 5);
    for (int p = 0; p < 4; p++) begin
      rd(4'(p), v);
      check($sformatf("R5 hold %0d", p), v, 32'(p + 2));
    end

    // R6 R7: held writes and commit
    for (int p = 0; p < 4; p++) begin
      a_val[p] = 32'h0100_0000 * 32'(p + 1) + 32'h10;
      wr(4'(p), a_val[p]);
      rd(4'(p), v);
      check($sformatf("R6 pending read %0d", p), v, a_val[p]);
    end
    wr(4'd8, 32'h1);
    pulse(8'h0F, 3);
    for (int p = 0; p < 4; p++) begin
      rd(4'(p), v);
      check($sformatf("R7 committed count %0d", p), v, a_val[p] + 32'd3);
    end
    x = 32'hCAFE_0000;
    wr(4'd0, x);
    pulse(8'h01, 4);
    rd(4'd0, v); check("R6 pending hides live", v, x);
    wr(4'd8, 32'h0);
    rd(4'd0, v); check("R7 no commit when disabled", v, x);
    wr(4'd8, 32'h1);
    rd(4'd0, v); check("R7 commit on rewrite", v, x);
    pulse(8'h01, 2);
    rd(4'd0, v); check("R7 counts from held value", v, x + 32'd2);
    a_val[0] = x - 32'd1;

    // R4 R8: split halves
    wr(4'd8, 32'h1F);
    for (int p = 0; p < 4; p++) begin
      u_val[p] = 16'h1100 + 16'(p);
      l_val[p] = 16'h0200 + 16'(p);
      wr(4'(p), {16'hDEAD, u_val[p]});
      rd(4'(p + 4), v);
      check($sformatf("R8 lower kept %0d", p), v, 32'(16'(a_val[p] + 32'd3)));
      wr(4'(p + 4), {16'hBEEF, l_val[p]});
      rd(4'(p), v);
      check($sformatf("R8 upper kept %0d", p), v, 32'(u_val[p]));
    end
    wr(4'd8, 32'h1F);
    wr(4'd8, 32'h01);
    for (int p = 0; p < 4; p++) begin
      rd(4'(p), v);
      check($sformatf("R4 half layout %0d", p), v, {u_val[p], l_val[p]});
    end
    wr(4'd8, 32'h1F);
    pulse(8'hF0, 3);
    pulse(8'h0F, 2);
    for (int p = 0; p < 4; p++) begin
      rd(4'(p), v);
      check($sformatf("R4 upper count %0d", p), v, 32'(u_val[p] + 16'd2));
      rd(4'(p + 4), v);
      check($sformatf("R4 lower count %0d", p), v, 32'(l_val[p] + 16'd3));
    end

    // R4 R9 R10: lower-half wrap, no carry
    for (int p = 0; p < 4; p++) begin
      wr(4'(p + 4), 32'hFFFE);
      wr(4'(p), 32'h7000);
    end
    wr(4'd8, 32'h1F);
    pulse(8'hF0, 3);
    for (int p = 0; p < 4; p++) begin
      rd(4'(p), v);     check($sformatf("R4 no carry %0d", p), v, 32'h7000);
      rd(4'(p + 4), v); check($sformatf("R4 lower wrap %0d", p), v, 32'h1);
    end
    rd(4'd9, v); check("R9 lower flags", v, 32'h00F0);
    rd(4'd9, v); check("R10 cleared by read", v, 32'h0);

    // R4 R9: upper-half wrap
    for (int p = 0; p < 4; p++) wr(4'(p), 32'hFFFF);
    wr(4'd8, 32'h1F);
    pulse(8'h0F, 1);
    for (int p = 0; p < 4; p++) begin
      rd(4'(p), v);     check($sformatf("R4 upper wrap %0d", p), v, 32'h0);
      rd(4'(p + 4), v); check($sformatf("R4 lower untouched %0d", p), v, 32'h1);
    end
    rd(4'd9, v); check("R9 upper flags", v, 32'h000F);

    // R9: 32-bit wrap
    wr(4'd8, 32'h01);
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd8, 32'h01);
    pulse(8'h04, 2);
    rd(4'd2, v); check("R9 32-bit wrap value", v, 32'h1);
    check("R11 irq masked off", 32'(irq_o), 32'h0);

    // R11: mask and interrupt
    wr(4'd9, 32'h04);
    check("R11 irq raised", 32'(irq_o), 32'h1);
    rd(4'd9, v); check("R9 status layout", v, 32'h0404);
    check("R11 irq after clear", 32'(irq_o), 32'h0);
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd8, 32'h01);
    pulse(8'h04, 1);
    check("R11 irq on new flag", 32'(irq_o), 32'h1);
    wr(4'd9, 32'h00);
    check("R11 zero mask drops irq", 32'(irq_o), 32'h0);
    rd(4'd9, v); check("R11 flags kept by mask write", v, 32'h0004);

    // R10: read and wrap in the same cycle
    wr(4'd3, 32'hFFFF_FFFF);
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd8, 32'h01);
    pulse(8'h08, 1);
    @(negedge clk); rd_en = 1'b1; rd_addr = 4'd9; evt_i = 8'h02;
    @(negedge clk); rd_en = 1'b0; evt_i = '0; v = rd_data;
    check("R10 read before collision", v, 32'h0008);
    rd(4'd9, v); check("R10 collision flag kept", v, 32'h0002);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule